// File: doc/BRIEF.md
# Four-Register Sequence Datapath

A narrow datapath for computing an additive sequence in a counted loop. It holds four general registers with one write port and two combinational read ports, an opcode-driven ALU that combines the two read operands, and a result register that captures the ALU output on every clock. The captured result drives the data-memory output and is also fed back as the register write value. A two-way selector picks whether a register write takes external load data or the fed-back result. A zero indicator reports when the loop-count register reaches zero.

An external sequencer drives the addresses, the opcode, the write enable and the load select on every cycle, and samples the zero indicator to leave the loop. The block works as a two-stage pipeline. An operation presented in one cycle lands in the result register at that clock edge. A register write in the next cycle with the load select low commits that result to a register. Register 0 holds the loop count, registers 1 and 2 hold the two latest sequence values, and register 3 is scratch.

Top module: `fib_datapath`

## Requirements
- R1: The active-low asynchronous reset clears all four registers and the result register to 0, so result_o reads 0 and zero_o reads 1 after reset.
- R2: With wr_en_i high and load_sel_i high, the register selected by wr_addr_i (0..3 selects register 0..3) takes load_data_i at the clock edge.
- R3: With wr_en_i high and load_sel_i low, the selected register takes the value result_o held before that edge.
- R4: With wr_en_i low, no register changes, whatever the other inputs are.
- R5: The ALU operands are the registers selected by rd_addr_a_i (A) and rd_addr_b_i (B), chosen independently. The result register captures the ALU output at every edge, so result_o shows an operation one cycle after it is presented.
- R6: Opcode 3'b110 yields A+B modulo 16.
- R7: Opcode 3'b011 yields A-1 modulo 16, so 0 becomes 15.
- R8: Opcode 3'b001 yields the constant 1.
- R9: Opcodes 3'b100 and 3'b101 yield A, opcode 3'b111 yields B, and opcodes 3'b000 and 3'b010 yield 0.
- R10: zero_o is high exactly when register 0 holds 0. It follows a write to register 0 in the same cycle, with no added register stage.
- R11: A register read in the same cycle as a write to that register returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_addr_i | input | 2 | Register selected for writing |
| wr_en_i | input | 1 | Write enable |
| load_sel_i | input | 1 | 1: write load_data_i, 0: write result_o |
| load_data_i | input | 4 | External write value |
| rd_addr_a_i | input | 2 | Register selected as operand A |
| rd_addr_b_i | input | 2 | Register selected as operand B |
| op_i | input | 3 | ALU opcode |
| result_o | output | 4 | Result register, sent to data memory and fed back |
| zero_o | output | 1 | High when register 0 is 0 |

## Verification
The assertions assume that every input is a defined 0 or 1 on each clock edge once reset has been released. They also assume that the opcode is any 3-bit value, so the unused codes must give 0 rather than be left unconstrained. The bench draws every address, opcode, enable and data value uniformly from the full range of each field, so no stimulus falls outside these assumptions. Between reset pulses it applies only synchronous changes at the falling clock edge. The directed part aims at the wrap of decrement at 0, sums that overflow, same-cycle read and write of one register, and long runs with the write enable held low.

// File: rtl/fib_dp_pkg.sv
package fib_dp_pkg;
  typedef enum logic [2:0] {
    OP_ZERO  = 3'b000,
    OP_ONE   = 3'b001,
    OP_RSVD  = 3'b010,
    OP_DEC   = 3'b011,
    OP_LDCNT = 3'b100,
    OP_EMIT  = 3'b101,
    OP_ADD   = 3'b110,
    OP_COPY  = 3'b111
  } alu_op_e;

  localparam int unsigned COUNT_REG = 0;
endpackage

// File: rtl/fib_regfile.sv
module fib_regfile #(
  parameter int unsigned DATA_W   = 4,
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [AW-1:0]                      waddr_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  input  logic [AW-1:0]                      raddr_a_i,
  input  logic [AW-1:0]                      raddr_b_i,
  output logic [DATA_W-1:0]                  rdata_a_o,
  output logic [DATA_W-1:0]                  rdata_b_o,
  output logic [NUM_REGS-1:0][DATA_W-1:0]    regs_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] q;
  logic [NUM_REGS-1:0]             sel;

  always_comb begin
    sel = '0;
    if (we_i) sel[waddr_i] = 1'b1;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q[g] <= '0;
      else if (sel[g]) q[g] <= wdata_i;
    end
  end

  // reads see pre-edge contents
  assign rdata_a_o = q[raddr_a_i];
  assign rdata_b_o = q[raddr_b_i];
  assign regs_o    = q;
endmodule

// File: rtl/fib_alu.sv
module fib_alu
  import fib_dp_pkg::*;
#(
  parameter int unsigned DATA_W = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        op_i,
  output logic [DATA_W-1:0] y_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  always_comb begin
    unique case (op)
      OP_ONE:           y_o = DATA_W'(1);
      OP_DEC:           y_o = a_i - DATA_W'(1);
      OP_LDCNT,
      OP_EMIT:          y_o = a_i;
      OP_COPY:          y_o = b_i;
      OP_ADD:           y_o = a_i + b_i;
      default:          y_o = '0;
    endcase
  end
endmodule

// File: rtl/fib_result_reg.sv
module fib_result_reg #(
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/fib_datapath.sv
module fib_datapath
  import fib_dp_pkg::*;
#(
  parameter int unsigned DATA_W   = 4,
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic              wr_en_i,
  input  logic              load_sel_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic [AW-1:0]     rd_addr_a_i,
  input  logic [AW-1:0]     rd_addr_b_i,
  input  logic [2:0]        op_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o
);
  logic [DATA_W-1:0]               opa, opb, alu_y, wdata;
  logic [NUM_REGS-1:0][DATA_W-1:0] rf_q;

  assign wdata = load_sel_i ? load_data_i : result_o;

  fib_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_en_i),
    .waddr_i   (wr_addr_i),
    .wdata_i   (wdata),
    .raddr_a_i (rd_addr_a_i),
    .raddr_b_i (rd_addr_b_i),
    .rdata_a_o (opa),
    .rdata_b_o (opb),
    .regs_o    (rf_q)
  );

  fib_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i  (opa),
    .b_i  (opb),
    .op_i (op_i),
    .y_o  (alu_y)
  );

  fib_result_reg #(.DATA_W(DATA_W)) u_res (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (alu_y),
    .q_o    (result_o)
  );

  assign zero_o = ~|rf_q[COUNT_REG];
endmodule

// File: rtl/fib_datapath_chk.sv
module fib_datapath_chk #(
  parameter int unsigned DATA_W   = 4,
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [AW-1:0]                   wr_addr_i,
  input logic                            wr_en_i,
  input logic                            load_sel_i,
  input logic [DATA_W-1:0]               load_data_i,
  input logic [2:0]                      op_i,
  input logic [DATA_W-1:0]               opa,
  input logic [DATA_W-1:0]               opb,
  input logic [NUM_REGS-1:0][DATA_W-1:0] rf_q,
  input logic [DATA_W-1:0]               result_o,
  input logic                            zero_o
);
  AST_LOAD_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && load_sel_i |=> rf_q[$past(wr_addr_i)] == $past(load_data_i)); // R2
  AST_FEEDBACK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !load_sel_i |=> rf_q[$past(wr_addr_i)] == $past(result_o)); // R3
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rf_q)); // R4
  AST_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'b110 |=> result_o == DATA_W'($past(opa) + $past(opb))); // R6
  AST_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'b011 |=> result_o == DATA_W'($past(opa) - 1'b1)); // R7
  AST_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'b001 |=> result_o == DATA_W'(1)); // R8
  AST_COPY_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'b111 |=> result_o == $past(opb)); // R9
  AST_ZERO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && load_sel_i && wr_addr_i == '0 && load_data_i == '0 |=> zero_o); // R10
endmodule

bind fib_datapath fib_datapath_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_addr_i   (wr_addr_i),
  .wr_en_i     (wr_en_i),
  .load_sel_i  (load_sel_i),
  .load_data_i (load_data_i),
  .op_i        (op_i),
  .opa         (opa),
  .opb         (opb),
  .rf_q        (rf_q),
  .result_o    (result_o),
  .zero_o      (zero_o)
);

// File: tb/fib_datapath_test.sv
module fib_datapath_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] wr_addr_i = '0, rd_addr_a_i = '0, rd_addr_b_i = '0;
  logic       wr_en_i = 1'b0, load_sel_i = 1'b0;
  logic [3:0] load_data_i = '0;
  logic [2:0] op_i = '0;
  logic [3:0] result_o;
  logic       zero_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [3:0] m_rf [4];
  logic [3:0] m_res;
  string      tag;

  always #2 clk_i = ~clk_i;

  fib_datapath uut (.*);

  function automatic logic [3:0] model_alu(logic [3:0] a, logic [3:0] b, logic [2:0] op);
    case (op)
      3'b001: return 4'd1;
      3'b011: return a - 4'd1;
      3'b100, 3'b101: return a;
      3'b111: return b;
      3'b110: return a + b;
      default: return 4'd0;
    endcase
  endfunction

  function automatic string op_tag(logic [2:0] op);
    case (op)
      3'b110: return "R6";
      3'b011: return "R7";
      3'b001: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string t, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic compare_now();
    check(tag, result_o, m_res);
    check("R10", {3'b0, zero_o}, {3'b0, m_rf[0] == 4'd0});
  endtask

  // one cycle: compare previous effect, drive new inputs, advance model
  task automatic drive(logic [1:0] wa, logic we, logic ls, logic [3:0] ld,
                       logic [1:0] ra, logic [1:0] rb, logic [2:0] op, string t);
    logic [3:0] nres;
    @(negedge clk_i);
    compare_now();
    wr_addr_i = wa; wr_en_i = we; load_sel_i = ls; load_data_i = ld;
    rd_addr_a_i = ra; rd_addr_b_i = rb; op_i = op;
    nres = model_alu(m_rf[ra], m_rf[rb], op);
    if (we) m_rf[wa] = ls ? ld : m_res;
    m_res = nres;
    tag = (t == "") ? op_tag(op) : t;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) m_rf[i] = '0;
    m_res = '0;
    tag = "R1";
    repeat (3) @(negedge clk_i);
    check("R1", result_o, 4'd0);
    check("R1", {3'b0, zero_o}, 4'd1);
    rst_ni = 1'b1;
    // R2 loads into each register, read back via pass A
    drive(2'd0, 1, 1, 4'd3, 0, 0, 3'b100, "R2");
    drive(2'd1, 1, 1, 4'd9, 0, 0, 3'b100, "R2");
    drive(2'd2, 1, 1, 4'd14, 1, 0, 3'b101, "R2");
    drive(2'd3, 1, 1, 4'd0, 2, 0, 3'b100, "R2");
    drive(2'd0, 0, 1, 4'd7, 3, 0, 3'b100, "R2");
    // R5/R6 independent operands, overflow 9+14=7
    drive(2'd0, 0, 0, 4'd0, 1, 2, 3'b110, "R6");
    drive(2'd0, 0, 0, 4'd0, 2, 1, 3'b111, "R5");
    // R3 feedback write of result (sum) into R3 then read
    drive(2'd0, 0, 0, 4'd0, 1, 2, 3'b110, "R6");
    drive(2'd3, 1, 0, 4'd5, 0, 0, 3'b000, "R9");
    drive(2'd0, 0, 0, 4'd0, 3, 0, 3'b100, "R3");
    // R7 wrap: R3 was loaded 0 earlier then overwritten; use R0 decrement loop to zero
    drive(2'd0, 1, 1, 4'd0, 0, 0, 3'b011, "R7");
    drive(2'd0, 0, 0, 4'd0, 0, 0, 3'b011, "R7");
    drive(2'd0, 1, 1, 4'd2, 0, 0, 3'b001, "R8");
    // R11 same-cycle write/read of R1 returns old value
    drive(2'd1, 1, 1, 4'd5, 1, 1, 3'b100, "R11");
    drive(2'd0, 0, 0, 4'd0, 1, 1, 3'b100, "R2");
    // R10 decrement count to zero with feedback writes
    drive(2'd0, 0, 0, 4'd0, 0, 0, 3'b011, "R7");
    drive(2'd0, 1, 0, 4'd0, 0, 0, 3'b011, "R10");
    drive(2'd0, 0, 0, 4'd0, 0, 0, 3'b011, "R7");
    drive(2'd0, 1, 0, 4'd0, 0, 0, 3'b100, "R10");
    // R4 enable low with random other inputs, then read each back
    for (int i = 0; i < 40; i++)
      drive(2'($urandom), 0, 1'($urandom), 4'($urandom), 2'($urandom), 2'($urandom), 3'($urandom), "");
    for (int r = 0; r < 4; r++) drive(2'd0, 0, 0, 4'd0, 2'(r), 0, 3'b101, "R4");
    drive(2'd0, 0, 0, 4'd0, 0, 0, 3'b010, "R9");
    // constrained random mix
    for (int i = 0; i < 3000; i++)
      drive(2'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
            2'($urandom), 2'($urandom), 3'($urandom), "");
    @(negedge clk_i);
    compare_now();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule